// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor Controller

This block is a small processor built around one accumulator. It steps through a fetch/execute instruction cycle against a single shared synchronous memory. It holds a program counter, an instruction register, an address register, a data register and the accumulator. A timing generator divides the clock into machine cycles of `MC_CLKS` clocks each. A sequencer gives every opcode a fixed number of machine cycles.

An instruction word is 12 bits wide. Bits 11:8 hold the opcode and bits 7:0 hold a direct memory address. There are five operations:

- clear the accumulator;
- add a memory word into the accumulator;
- store the accumulator to memory;
- do nothing;
- jump unconditionally.

The processor reads and writes a 256-word RAM through an address, a write-data bus, a read strobe and a write strobe. The RAM returns read data one clock after it samples the address. A one-clock pulse marks the last clock of every instruction, so the instruction timing can be observed from outside.

Top module: `acc_cpu`

## Requirements
- R1: Every instruction starts with one fetch machine cycle. During that cycle the read strobe is high and the address is the PC. At its end the word read is loaded into the instruction register, the opcode (bits 11:8) is decoded, and the PC advances by one modulo 256.
- R2: Opcode 0x1 (clear) takes 2 machine cycles. Afterwards the accumulator is 0, the zero flag is 1 and the carry flag is 0.
- R3: Opcode 0x2 (add) takes 3 machine cycles. Afterwards the accumulator is (AC + M[addr]) mod 4096. Carry is the bit shifted out of the sum, and zero is 1 exactly when the new accumulator is 0.
- R4: Opcode 0x3 (store) takes 3 machine cycles. It raises the write strobe for exactly one clock, with address = addr field and write data = AC. The accumulator and both flags are left unchanged.
- R5: For add and store, the second machine cycle only sets up the address and asserts no memory strobe. In the third machine cycle the memory address equals the address field, and add holds the read strobe high for the whole cycle.
- R6: Opcode 0x0 and the unused opcodes 0x5 to 0xF take 2 machine cycles. No memory strobe is asserted in their execute cycle, and the accumulator and flags are unchanged.
- R7: Opcode 0x4 (jump) takes 2 machine cycles. The next fetch reads from the address field.
- R8: A machine cycle is `MC_CLKS` clocks long. `instr_done_o` is high for exactly the last clock of each instruction, and the next fetch starts on the following clock.
- R9: While `rst_ni` is low, the PC, accumulator, carry and zero flags are 0, the processor sits in the first clock of a fetch (read strobe high, address 0), and the write strobe and done pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory word address |
| mem_rd_o | output | 1 | Read strobe |
| mem_we_o | output | 1 | Write strobe, one clock per store |
| mem_wdata_o | output | 12 | Write data |
| mem_rdata_i | input | 12 | Read data, valid one clock after the address |
| instr_done_o | output | 1 | High on the last clock of each instruction |
| acc_o | output | 12 | Accumulator |
| carry_o | output | 1 | Carry from the last add, cleared by clear |
| zero_o | output | 1 | Accumulator-is-zero flag, updated by clear and add |

## Verification
The assertions take for granted that read data follows a memory with one clock of read latency. They also assume that the address is not sampled from undriven data, since every fetched word decides the next state.

The bench keeps within these assumptions. Its memory model registers the read data on every clock, and every one of its 256 words is written while reset is held, before the processor runs. Reset is released just after a falling edge, and it is reasserted only while a no-operation word is executing, so no store is cut short.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [2:0] {
    K_NOP,
    K_CLA,
    K_ADD,
    K_STA,
    K_JMP
  } kind_e;

  typedef enum logic [1:0] {
    S_FETCH,
    S_EXEC,
    S_ADDR,
    S_MEM
  } state_e;

  typedef struct packed {
    logic ir_ld;
    logic pc_inc;
    logic pc_jmp;
    logic ar_ld;
    logic acc_clr;
    logic acc_add;
    logic mem_rd;
    logic mem_we;
    logic done;
  } ctrl_t;

  function automatic kind_e decode_op(input logic [OP_W-1:0] raw);
    case (raw)
      4'h1:    return K_CLA;
      4'h2:    return K_ADD;
      4'h3:    return K_STA;
      4'h4:    return K_JMP;
      default: return K_NOP;
    endcase
  endfunction

endpackage

// File: rtl/acc_cpu_timing.sv
module acc_cpu_timing #(
  parameter int MC_CLKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic mc_first_o,
  output logic mc_last_o
);

  localparam int PH_W = (MC_CLKS > 2) ? $clog2(MC_CLKS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(MC_CLKS - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else                     phase_q <= phase_q + PH_W'(1);
  end

  assign mc_first_o = (phase_q == '0);
  assign mc_last_o  = (phase_q == PH_LAST);

  assert_phase_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q <= PH_LAST);

  assert_phase_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mc_last_o |=> mc_first_o);

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mc_last_i,
  input  logic [OP_W-1:0] fetch_op_i,
  output state_e          state_o,
  output ctrl_t           ctrl_o
);

  state_e state_q, state_d;
  kind_e  kind_q;
  kind_e  fetch_kind;

  assign fetch_kind = decode_op(fetch_op_i);

  always_comb begin
    state_d = state_q;
    if (mc_last_i) begin
      case (state_q)
        S_FETCH: state_d = (fetch_kind == K_ADD || fetch_kind == K_STA) ? S_ADDR : S_EXEC;
        S_EXEC:  state_d = S_FETCH;
        S_ADDR:  state_d = S_MEM;
        S_MEM:   state_d = S_FETCH;
        default: state_d = S_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      kind_q  <= K_NOP;
    end else begin
      state_q <= state_d;
      if (state_q == S_FETCH && mc_last_i) kind_q <= fetch_kind;
    end
  end

  always_comb begin
    ctrl_o = '0;
    case (state_q)
      S_FETCH: begin
        ctrl_o.mem_rd = 1'b1;
        ctrl_o.ir_ld  = mc_last_i;
        ctrl_o.pc_inc = mc_last_i;
      end
      S_EXEC: begin
        // no-op class: nothing asserted besides the done pulse
        ctrl_o.acc_clr = mc_last_i && (kind_q == K_CLA);
        ctrl_o.pc_jmp  = mc_last_i && (kind_q == K_JMP);
        ctrl_o.done    = mc_last_i;
      end
      S_ADDR: begin
        ctrl_o.ar_ld = mc_last_i;
      end
      S_MEM: begin
        ctrl_o.mem_rd  = (kind_q == K_ADD);
        ctrl_o.acc_add = mc_last_i && (kind_q == K_ADD);
        ctrl_o.mem_we  = mc_last_i && (kind_q == K_STA);
        ctrl_o.done    = mc_last_i;
      end
      default: ctrl_o = '0;
    endcase
  end

  assign state_o = state_q;

  assert_next_is_fetch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.done |=> (state_q == S_FETCH));

  assert_exec_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXEC || state_q == S_ADDR) |-> (!ctrl_o.mem_rd && !ctrl_o.mem_we));

  assert_we_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.mem_we |=> !ctrl_o.mem_we);

  assert_strobe_excl_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ctrl_o.mem_rd, ctrl_o.mem_we}));

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] ar_o,
  output logic [DATA_W-1:0] dr_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic              zero_o
);

  logic [ADDR_W-1:0] pc_q, ar_q;
  logic [DATA_W-1:0] ir_q, dr_q, acc_q;
  logic              carry_q, zero_q;
  logic [DATA_W:0]   sum;

  assign sum = {1'b0, acc_q} + {1'b0, mem_rdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      ar_q    <= '0;
      ir_q    <= '0;
      dr_q    <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (ctrl_i.ir_ld) ir_q <= mem_rdata_i;
      if (ctrl_i.pc_jmp)      pc_q <= ir_q[ADDR_W-1:0];
      else if (ctrl_i.pc_inc) pc_q <= pc_q + ADDR_W'(1);
      if (ctrl_i.ar_ld) begin
        ar_q <= ir_q[ADDR_W-1:0];
        dr_q <= acc_q;
      end
      if (ctrl_i.acc_clr) begin
        acc_q   <= '0;
        carry_q <= 1'b0;
        zero_q  <= 1'b1;
      end else if (ctrl_i.acc_add) begin
        acc_q   <= sum[DATA_W-1:0];
        carry_q <= sum[DATA_W];
        zero_q  <= (sum[DATA_W-1:0] == '0);
      end
    end
  end

  assign pc_o    = pc_q;
  assign ar_o    = ar_q;
  assign dr_o    = dr_q;
  assign acc_o   = acc_q;
  assign carry_o = carry_q;
  assign zero_o  = zero_q;

  assert_pc_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.pc_inc && !ctrl_i.pc_jmp) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

  assert_pc_excl_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_i.pc_inc && ctrl_i.pc_jmp));

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.acc_clr |=> (acc_q == '0 && zero_q && !carry_q));

  assert_zero_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.acc_add |=> (zero_q == (acc_q == '0)));

  assert_jump_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.pc_jmp |=> (pc_q == $past(ir_q[ADDR_W-1:0])));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int ADDR_W  = DATA_W - OP_W,
  parameter int MC_CLKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              instr_done_o,
  output logic [DATA_W-1:0] acc_o,
  output logic              carry_o,
  output logic              zero_o
);

  logic              mc_first, mc_last;
  state_e            state;
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] pc, ar;
  logic [DATA_W-1:0] dr;

  acc_cpu_timing #(.MC_CLKS(MC_CLKS)) u_timing (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mc_first_o (mc_first),
    .mc_last_o  (mc_last)
  );

  acc_cpu_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mc_last_i  (mc_last),
    .fetch_op_i (mem_rdata_i[DATA_W-1 -: OP_W]),
    .state_o    (state),
    .ctrl_o     (ctrl)
  );

  acc_cpu_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .mem_rdata_i (mem_rdata_i),
    .pc_o        (pc),
    .ar_o        (ar),
    .dr_o        (dr),
    .acc_o       (acc_o),
    .carry_o     (carry_o),
    .zero_o      (zero_o)
  );

  assign mem_addr_o   = (state == S_FETCH) ? pc : ar;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_we_o     = ctrl.mem_we;
  assign mem_wdata_o  = dr;
  assign instr_done_o = ctrl.done;

  assert_done_realign_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_done_o |=> mc_first);

  assert_ar_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == S_MEM && !mc_first) |-> $stable(ar));

  assert_wdata_acc_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == acc_o));

endmodule

// File: tb/sim_acc_cpu.sv
`timescale 1ns/1ps
module sim_acc_cpu;

  localparam int DW = 12;
  localparam int AW = 8;
  localparam int MC = 2;

  typedef struct {
    int          kind;
    int          cyc;
    int          rd;
    int          we;
    logic [AW-1:0] waddr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] acc;
    logic        c;
    logic        z;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_we, done, carry, zero;
  logic [DW-1:0] mem_wdata, acc;
  logic [DW-1:0] rdata = '0;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] model_mem [256];
  logic          ld_en = 1'b0;
  logic [AW-1:0] ld_a = '0;
  logic [DW-1:0] ld_d = '0;

  acc_cpu #(.DATA_W(DW), .MC_CLKS(MC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata),
    .instr_done_o(done), .acc_o(acc), .carry_o(carry), .zero_o(zero)
  );

  always @(posedge clk) begin
    if (ld_en)       mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    rdata <= mem[mem_addr];
  end

  int n_cmp = 0;
  int n_bad = 0;
  item_t q[$];
  item_t pend_it;
  logic  pend = 1'b0;
  logic  mon_en = 1'b0;
  int    cyc_c, rd_c, we_c;
  logic [AW-1:0] wa_seen;
  logic [DW-1:0] wd_seen;

  logic [AW-1:0] m_pc;
  logic [DW-1:0] m_acc;
  logic          m_c, m_z;

  function automatic string tag(int k);
    case (k)
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (pend) begin
        chk(tag(pend_it.kind), "acc", 32'(acc), 32'(pend_it.acc));
        chk(tag(pend_it.kind), "carry", 32'(carry), 32'(pend_it.c));
        chk(tag(pend_it.kind), "zero", 32'(zero), 32'(pend_it.z));
        pend = 1'b0;
      end
      cyc_c++;
      if (mem_rd) rd_c++;
      if (mem_we) begin
        we_c++;
        wa_seen = mem_addr;
        wd_seen = mem_wdata;
      end
      if (done) begin
        if (q.size() == 0) begin
          chk("R8", "unexpected done", 32'(1), 32'(0));
        end else begin
          pend_it = q.pop_front();
          chk("R8", {tag(pend_it.kind), " clocks"}, 32'(cyc_c), 32'(pend_it.cyc));
          chk("R1/R5", {tag(pend_it.kind), " read clocks"}, 32'(rd_c), 32'(pend_it.rd));
          chk("R4", {tag(pend_it.kind), " write clocks"}, 32'(we_c), 32'(pend_it.we));
          if (pend_it.we != 0) begin
            chk("R5", "write address", 32'(wa_seen), 32'(pend_it.waddr));
            chk("R4", "write data", 32'(wd_seen), 32'(pend_it.wdata));
          end
          pend = 1'b1;
        end
        cyc_c = 0;
        rd_c  = 0;
        we_c  = 0;
      end
    end
  end

  // driver: reference execution pushes expected items
  task automatic push_run(int n);
    for (int i = 0; i < n; i++) begin
      item_t it;
      logic [DW-1:0] w;
      logic [DW:0]   s;
      w = model_mem[m_pc];
      m_pc = m_pc + AW'(1);
      it.kind = 0; it.cyc = 2 * MC; it.rd = MC; it.we = 0;
      it.waddr = '0; it.wdata = '0;
      case (w[11:8])
        4'h1: begin it.kind = 1; m_acc = '0; m_c = 1'b0; m_z = 1'b1; end
        4'h2: begin
          it.kind = 2; it.cyc = 3 * MC; it.rd = 2 * MC;
          s = {1'b0, m_acc} + {1'b0, model_mem[w[7:0]]};
          m_acc = s[DW-1:0]; m_c = s[DW]; m_z = (s[DW-1:0] == '0);
        end
        4'h3: begin
          it.kind = 3; it.cyc = 3 * MC; it.we = 1;
          it.waddr = w[7:0]; it.wdata = m_acc;
          model_mem[w[7:0]] = m_acc;
        end
        4'h4: begin it.kind = 4; m_pc = w[7:0]; end
        default: it.kind = 0;
      endcase
      it.acc = m_acc; it.c = m_c; it.z = m_z;
      q.push_back(it);
    end
  endtask

  task automatic load(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_a = a; ld_d = d;
    model_mem[a] = d;
  endtask

  task automatic check_reset();
    chk("R9", "acc", 32'(acc), 32'(0));
    chk("R9", "carry", 32'(carry), 32'(0));
    chk("R9", "zero", 32'(zero), 32'(0));
    chk("R9", "done", 32'(done), 32'(0));
    chk("R9", "read strobe", 32'(mem_rd), 32'(1));
    chk("R9", "write strobe", 32'(mem_we), 32'(0));
    chk("R9", "address", 32'(mem_addr), 32'(0));
  endtask

  task automatic release_run();
    @(negedge clk);
    #1;
    rst_ni = 1'b1;
    cyc_c = 1; rd_c = 1; we_c = 0; pend = 1'b0;
    mon_en = 1'b1;
  endtask

  task automatic drain();
    int t = 0;
    while ((q.size() != 0 || pend) && t < 5000) begin
      @(negedge clk);
      #1;
      t++;
    end
    if (t >= 5000) chk("R8", "drain timeout", 32'(1), 32'(0));
    mon_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R8 watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < 256; a++) load(AW'(a), '0);
    load(8'h00, 12'h100); // clear
    load(8'h01, 12'h230); // add 30
    load(8'h02, 12'h231); // add 31: wraps to 0, carry
    load(8'h03, 12'h230);
    load(8'h04, 12'h340); // store 40
    load(8'h05, 12'h000); // nop
    load(8'h06, 12'h5AB); // unused opcode
    load(8'h07, 12'h40A); // jump 0A
    load(8'h08, 12'h100);
    load(8'h09, 12'h100);
    load(8'h0A, 12'h240); // add 40
    load(8'h0B, 12'h341);
    load(8'h0C, 12'hF00);
    load(8'h0D, 12'h4FE); // jump FE
    load(8'hFE, 12'h231);
    load(8'hFF, 12'h342); // PC then wraps to 00 (R1)
    load(8'h30, 12'h7FF);
    load(8'h31, 12'h801);
    @(negedge clk);
    ld_en = 1'b0;
    repeat (2) @(negedge clk);
    #1 check_reset();

    m_pc = '0; m_acc = '0; m_c = 1'b0; m_z = 1'b0;
    push_run(20);
    release_run();
    drain();

    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    #1 check_reset();

    m_pc = '0; m_acc = '0; m_c = 1'b0; m_z = 1'b0;
    push_run(16);
    release_run();
    drain();

    for (int a = 8'h40; a <= 8'h42; a++)
      chk("R4", "memory word", 32'(mem[a]), 32'(model_mem[a]));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule